// File: doc/BRIEF.md
# Serial Receive Character Buffer with Sticky Status

This block sits between a serial receiver's shift engine and the register bus. Each time the shift engine completes a character, it presents the byte together with framing-error, parity-error and break indications. The block stores the byte and those three flags as one entry in a first-in first-out buffer of `DEPTH` entries, which is 32 by default.

Software reads entries one at a time with a read strobe. Each read produces a 16-bit word that carries the character and its own per-character status bits. The block also reports the following at the port level:

- whether the buffer is empty or full;
- whether any data is present;
- whether the fill has reached a programmable trigger level;
- a set of sticky event flags.

Software clears the sticky flags by writing ones. A synchronous soft reset empties the buffer and clears every sticky flag.

When a character arrives while the buffer is full and no entry is leaving in the same cycle, the character is lost. In that case the newest stored entry is tagged as overrun, and the sticky overrun flag is set.

Top module: `uart_rx_fifo`

## Requirements
- R1: A read word holds the character in bits 7:0 and the valid mark in bit 15. Bit 14 is the OR of bits 13..10. Bit 13 is overrun, bit 12 is framing error, bit 11 is break and bit 10 is parity error. Bits 9:8 are zero.
- R2: Entries are returned in arrival order. The word for a read strobe sampled at a clock edge appears on `rd_word` after that edge and holds until the next read.
- R3: A read strobe while the buffer is empty makes `rd_word` all zero, so bit 15 is clear. The read position does not move, so the next stored character is still returned first.
- R4: `rx_empty` is 1 exactly when no entry is stored. `rx_full` is 1 exactly when `DEPTH` entries are stored.
- R5: `data_ready` is 1 whenever at least one entry is stored.
- R6: `thresh_ready` is 1 when the stored count is at least `trig_level`. A level of 0 acts as 1.
- R7: A character that arrives while the buffer is full, with no read in the same cycle, is dropped. The newest stored entry then reads back with bit 13 set, and `sts_flags[0]` becomes 1.
- R8: `sts_flags` bits are sticky: bit 0 is overrun, bit 1 is framing, bit 2 is parity and bit 3 is break. A sticky bit sets when an arriving character carries that error. A write of `sts_clr_bits` clears each bit given as 1 and leaves bits given as 0 unchanged. A set in the same cycle wins over a clear.
- R9: `soft_rst` empties the buffer, clears `sts_flags` and clears `rd_word` on the next edge.
- R10: A character that arrives while the buffer is full, in the same cycle as a read, is stored, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of buffer, flags and read word |
| rx_valid | input | 1 | Character strobe from the shift engine |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Framing error for this character |
| rx_parity_err | input | 1 | Parity error for this character |
| rx_break | input | 1 | Break condition for this character |
| rd_strobe | input | 1 | Read of one entry from the register bus |
| trig_level | input | LW | Receive trigger level |
| sts_clr_wr | input | 1 | Write strobe for the sticky-flag clear |
| sts_clr_bits | input | 4 | Write-one-to-clear mask for `sts_flags` |
| rd_word | output | 16 | Read-data word |
| rx_empty | output | 1 | Buffer empty |
| rx_full | output | 1 | Buffer full |
| data_ready | output | 1 | At least one entry stored |
| thresh_ready | output | 1 | Fill at or above trigger level |
| sts_flags | output | 4 | Sticky flags: overrun, framing, parity, break |

## Verification
Every result is due one clock edge after its stimulus:

- a character strobe updates the empty, full, ready and threshold outputs and the sticky flags at the next edge;
- a read strobe loads `rd_word` at the next edge;
- a clear write or soft reset takes effect at the next edge.

The bench drives each stimulus on a falling edge and removes it on the following falling edge. It samples the outputs at that same falling edge, half a period after the edge that registers the result. Threshold and full/empty checks are therefore made after each individual push, and read words are compared after each individual strobe.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic       ovr;
    logic       frm;
    logic       brk;
    logic       par;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  // Build the bus-visible word from a stored entry.
  function automatic logic [15:0] fmt_word(input logic valid, input rx_entry_t e);
    logic any_err;
    any_err = e.ovr | e.frm | e.brk | e.par;
    return valid ? {1'b1, any_err, e.ovr, e.frm, e.brk, e.par, 2'b00, e.data} : 16'h0000;
  endfunction

  // Fill versus trigger level, level 0 treated as 1.
  function automatic logic thresh_met(input int unsigned fill, input int unsigned lvl);
    int unsigned eff;
    eff = (lvl == 0) ? 1 : lvl;
    return fill >= eff;
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            push_req,
  input  rx_entry_t       push_entry,
  input  logic            pop_req,
  output rx_entry_t       head_entry,
  output logic [CW-1:0]   count,
  output logic            pop_ok,
  output logic            drop_evt
);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_prev(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign pop_ok   = pop_req && (count != '0) && !soft_rst;
  assign push_ok  = push_req && !soft_rst && ((count != CW'(DEPTH)) || pop_ok);
  assign drop_evt = push_req && !soft_rst && !push_ok;
  assign head_entry = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
    else if (drop_evt) mem[ptr_prev(wr_ptr)].ovr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (soft_rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

endmodule

// File: rtl/rxf_sticky.sv
module rxf_sticky #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [NF-1:0] set_vec,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_bits,
  output logic [NF-1:0] flags
);

  logic [NF-1:0] clr_mask;
  assign clr_mask = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (soft_rst) flags <= '0;
    else               flags <= (flags & ~clr_mask) | set_vec;
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_frame_err,
  input  logic          rx_parity_err,
  input  logic          rx_break,
  input  logic          rd_strobe,
  input  logic [LW-1:0] trig_level,
  input  logic          sts_clr_wr,
  input  logic [3:0]    sts_clr_bits,
  output logic [15:0]   rd_word,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          data_ready,
  output logic          thresh_ready,
  output logic [3:0]    sts_flags
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  rx_entry_t     in_entry, head_entry;
  logic [CW-1:0] count;
  logic          pop_ok;
  logic          drop_evt;
  logic [3:0]    flag_set;

  assign in_entry = '{ovr: 1'b0, frm: rx_frame_err, brk: rx_break,
                      par: rx_parity_err, data: rx_data};

  rxf_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .push_req   (rx_valid),
    .push_entry (in_entry),
    .pop_req    (rd_strobe),
    .head_entry (head_entry),
    .count      (count),
    .pop_ok     (pop_ok),
    .drop_evt   (drop_evt)
  );

  assign flag_set = {rx_valid & rx_break, rx_valid & rx_parity_err,
                     rx_valid & rx_frame_err, drop_evt};

  rxf_sticky #(.NF(4)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .set_vec  (flag_set),
    .clr_wr   (sts_clr_wr),
    .clr_bits (sts_clr_bits),
    .flags    (sts_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_word <= '0;
    else if (soft_rst)  rd_word <= '0;
    else if (rd_strobe) rd_word <= fmt_word(pop_ok, head_entry);
  end

  assign rx_empty     = (count == '0);
  assign rx_full      = (count == CW'(DEPTH));
  assign data_ready   = (count != '0);
  assign thresh_ready = thresh_met(32'(count), 32'(trig_level));

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        rx_valid,
  input logic        rd_strobe,
  input logic        sts_clr_wr,
  input logic [3:0]  sts_clr_bits,
  input logic [15:0] rd_word,
  input logic        rx_empty,
  input logic        rx_full,
  input logic        data_ready,
  input logic        thresh_ready,
  input logic [3:0]  sts_flags,
  input logic        drop_evt
);

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rx_empty) |=> (rd_word[15] == 1'b0));

  assert_not_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full));

  assert_push_leaves_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !soft_rst) |=> data_ready);

  assert_thresh_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_ready |-> data_ready);

  assert_drop_sets_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (sts_flags[0] && rx_full));

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flags[0] && !soft_rst && !(sts_clr_wr && sts_clr_bits[0])) |=> sts_flags[0]);

  assert_frm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flags[1] && !soft_rst && !(sts_clr_wr && sts_clr_bits[1])) |=> sts_flags[1]);

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rx_empty && (sts_flags == 4'b0000) && (rd_word == 16'h0000)));

  assert_no_drop_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rd_strobe) |-> !drop_evt);

endmodule

bind uart_rx_fifo rxf_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst     (soft_rst),
  .rx_valid     (rx_valid),
  .rd_strobe    (rd_strobe),
  .sts_clr_wr   (sts_clr_wr),
  .sts_clr_bits (sts_clr_bits),
  .rd_word      (rd_word),
  .rx_empty     (rx_empty),
  .rx_full      (rx_full),
  .data_ready   (data_ready),
  .thresh_ready (thresh_ready),
  .sts_flags    (sts_flags),
  .drop_evt     (drop_evt)
);

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;

  localparam int DEPTH = 32;
  localparam int LW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_frame_err = 1'b0;
  logic          rx_parity_err = 1'b0;
  logic          rx_break = 1'b0;
  logic          rd_strobe = 1'b0;
  logic [LW-1:0] trig_level = '0;
  logic          sts_clr_wr = 1'b0;
  logic [3:0]    sts_clr_bits = '0;
  logic [15:0]   rd_word;
  logic          rx_empty, rx_full, data_ready, thresh_ready;
  logic [3:0]    sts_flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_rx_fifo #(.DEPTH(DEPTH), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .rx_break(rx_break), .rd_strobe(rd_strobe), .trig_level(trig_level),
    .sts_clr_wr(sts_clr_wr), .sts_clr_bits(sts_clr_bits), .rd_word(rd_word),
    .rx_empty(rx_empty), .rx_full(rx_full), .data_ready(data_ready),
    .thresh_ready(thresh_ready), .sts_flags(sts_flags)
  );

  function automatic logic [15:0] exp_word(input logic [7:0] d, input logic f,
                                           input logic p, input logic b, input logic o);
    logic [15:0] w;
    w = 16'h0;
    w[7:0] = d;
    w[15]  = 1'b1;
    w[13]  = o;
    w[12]  = f;
    w[11]  = b;
    w[10]  = p;
    w[14]  = o | f | b | p;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic f, input logic p, input logic b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_frame_err = f; rx_parity_err = p; rx_break = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0; rx_break = 1'b0;
  endtask

  task automatic rd(output logic [15:0] w);
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    w = rd_word;
  endtask

  task automatic do_soft_rst();
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic clr(input logic [3:0] m);
    @(negedge clk);
    sts_clr_wr = 1'b1; sts_clr_bits = m;
    @(negedge clk);
    sts_clr_wr = 1'b0; sts_clr_bits = '0;
  endtask

  task automatic t_reset();
    chk("R4 reset empty", rx_empty, 1);
    chk("R4 reset full", rx_full, 0);
    chk("R5 reset ready", data_ready, 0);
    chk("R9 reset flags", sts_flags, 0);
    chk("R2 reset word", rd_word, 0);
  endtask

  task automatic t_format();
    logic [15:0] w;
    push(8'hA5, 0, 0, 0);
    chk("R5 ready after push", data_ready, 1);
    chk("R4 not empty", rx_empty, 0);
    push(8'h3C, 1, 0, 0);
    push(8'h81, 0, 1, 0);
    push(8'h00, 0, 0, 1);
    rd(w); chk("R1 plain word", w, exp_word(8'hA5, 0, 0, 0, 0));
    rd(w); chk("R1 framing word", w, exp_word(8'h3C, 1, 0, 0, 0));
    rd(w); chk("R1 parity word", w, exp_word(8'h81, 0, 1, 0, 0));
    rd(w); chk("R2 order break word", w, exp_word(8'h00, 0, 0, 1, 0));
    chk("R4 empty after drain", rx_empty, 1);
    do_soft_rst();
  endtask

  task automatic t_empty_read();
    logic [15:0] w;
    rd(w); chk("R3 empty read word", w, 16'h0000);
    chk("R4 still empty", rx_empty, 1);
    push(8'h5A, 0, 0, 0);
    rd(w); chk("R3 pointer unmoved", w, exp_word(8'h5A, 0, 0, 0, 0));
  endtask

  task automatic t_threshold();
    trig_level = 6'd4;
    for (int i = 0; i < 3; i++) push(8'(i), 0, 0, 0);
    chk("R6 below level", thresh_ready, 0);
    push(8'h03, 0, 0, 0);
    chk("R6 at level", thresh_ready, 1);
    do_soft_rst();
    trig_level = 6'd0;
    chk("R6 level0 empty", thresh_ready, 0);
    push(8'h11, 0, 0, 0);
    chk("R6 level0 one entry", thresh_ready, 1);
    do_soft_rst();
  endtask

  task automatic t_overrun();
    logic [15:0] w;
    for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i), 0, 0, 0);
    chk("R4 full at depth", rx_full, 1);
    chk("R7 no ovr yet", sts_flags[0], 0);
    push(8'hEE, 0, 0, 0);
    chk("R7 ovr flag", sts_flags[0], 1);
    chk("R7 still full", rx_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(w);
      chk("R7 drained word", w, exp_word(8'(8'h40 + i), 0, 0, 0, i == DEPTH - 1));
    end
    chk("R7 dropped char absent", rx_empty, 1);
    do_soft_rst();
  endtask

  task automatic t_simul();
    logic [15:0] w;
    for (int i = 0; i < DEPTH; i++) push(8'(i), 0, 0, 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h77; rd_strobe = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rd_strobe = 1'b0;
    chk("R10 word", rd_word, exp_word(8'h00, 0, 0, 0, 0));
    chk("R10 no ovr", sts_flags[0], 0);
    chk("R10 still full", rx_full, 1);
    for (int i = 1; i < DEPTH; i++) rd(w);
    rd(w); chk("R10 stored char", w, exp_word(8'h77, 0, 0, 0, 0));
    do_soft_rst();
  endtask

  task automatic t_sticky();
    push(8'h10, 1, 1, 1);
    chk("R8 flags set", sts_flags, 4'b1110);
    clr(4'b0000);
    chk("R8 zero write no effect", sts_flags, 4'b1110);
    clr(4'b0010);
    chk("R8 clear framing", sts_flags, 4'b1100);
    @(negedge clk);
    sts_clr_wr = 1'b1; sts_clr_bits = 4'b0100;
    rx_valid = 1'b1; rx_data = 8'h20; rx_parity_err = 1'b1;
    @(negedge clk);
    sts_clr_wr = 1'b0; sts_clr_bits = '0; rx_valid = 1'b0; rx_parity_err = 1'b0;
    chk("R8 set wins", sts_flags, 4'b1100);
    clr(4'b1111);
    chk("R8 clear all", sts_flags, 4'b0000);
  endtask

  task automatic t_softrst();
    push(8'h01, 1, 0, 0);
    push(8'h02, 0, 0, 0);
    do_soft_rst();
    chk("R9 empty", rx_empty, 1);
    chk("R9 flags", sts_flags, 0);
    chk("R9 word", rd_word, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_format();
    t_empty_read();
    t_threshold();
    t_overrun();
    t_simul();
    t_sticky();
    t_softrst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule